// File: doc/BRIEF.md
# Change-of-State Event Capture FIFO

This block samples a bank of parallel digital inputs every clock and records a snapshot into a data FIFO whenever a watched channel changes level. Each channel has its own watch enable, and only changes on enabled channels raise an event. The stored word always holds every channel, with channel n in bit n.

Two capture modes are selectable. In single-word mode an event stores only the new input value. In before/after mode it stores two words: the sampled value from just before the change, then the value that raised the event. Either way, a second FIFO takes exactly one entry per event. That entry is a free-running cycle timestamp, so software can recover when each event happened. The data FIFO is drained through a read strobe with byte enables. Only a read with all four byte enables set pops a word. Narrower reads are dropped.

An event that cannot fit is discarded whole and leaves a sticky overflow flag. A full-width read of an empty FIFO returns zero and leaves a sticky underflow flag. Both flags clear only on reset.

Top module: `cos_event_fifo`

## Requirements
- R1: In single-word mode (soe_mode=0), each event pushes one word holding the new sampled input, with channel n in bit n and disabled channels included at their current level.
- R2: In before/after mode (soe_mode=1), each event pushes two words, read out in order: the input sampled just before the change, then the changed input.
- R3: The timestamp FIFO gets exactly one entry per accepted event in either mode. Each entry holds a free-running cycle count taken at the event, so two events k cycles apart differ by k.
- R4: An event is raised only when a channel whose ch_en bit is 1 differs between two consecutive samples. Toggling a channel whose enable bit is 0 stores nothing.
- R5: A read with rd_stb=1 and rd_be=4'hF pops the oldest word. The word appears on rd_data with rd_valid=1 one cycle after the strobe.
- R6: A read with rd_stb=1 and any rd_be bit 0 is ignored. rd_valid stays 0 and the stored level is unchanged.
- R7: An event needs one free data entry in single-word mode and two in before/after mode. Otherwise it is dropped entirely and overflow is set and held until reset.
- R8: A full-width read of an empty data FIFO gives rd_data=0 with rd_valid=1 and sets underflow, which is held until reset.
- R9: level reports the number of stored data words. empty is 1 exactly when level is 0, and full is 1 exactly when level equals DEPTH.
- R10: After reset the FIFOs are empty and both flags are clear. The input values present when reset is released do not raise an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | W | Channel input levels |
| ch_en | input | W | Per-channel change watch enable |
| soe_mode | input | 1 | 1 selects before/after capture |
| rd_stb | input | 1 | Data FIFO read strobe |
| rd_be | input | 4 | Byte enables of the read |
| rd_data | output | W | Popped data word |
| rd_valid | output | 1 | rd_data holds a result of a full-width read |
| ts_rd_stb | input | 1 | Timestamp FIFO read strobe |
| ts_data | output | TS_W | Popped timestamp |
| ts_valid | output | 1 | ts_data holds a read result |
| ts_empty | output | 1 | Timestamp FIFO is empty |
| empty | output | 1 | Data FIFO is empty |
| full | output | 1 | Data FIFO is full |
| level | output | $clog2(DEPTH+1) | Stored data word count |
| overflow | output | 1 | Sticky: an event was dropped |
| underflow | output | 1 | Sticky: an empty FIFO was read |

## Verification
Single-word capture is driven with a sequence of distinct words. This shows that values come out in arrival order and that one word is stored per change. The same kind of change is repeated in before/after mode, where the two popped words must be the old and new values in that order. A mask that hides the low half of the channels separates toggles that must be ignored from toggles that must be recorded. Filling a small FIFO, then switching modes with one slot left, shows that the two-slot rule drops only the paired write. Timestamp spacing between events placed a known number of cycles apart confirms one stamp per event.

// File: rtl/cos_event_fifo.sv
`timescale 1ns/1ps
module cos_event_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 512,
  parameter int TS_W  = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    din,
  input  logic [W-1:0]    ch_en,
  input  logic            soe_mode,
  input  logic            rd_stb,
  input  logic [3:0]      rd_be,
  output logic [W-1:0]    rd_data,
  output logic            rd_valid,
  input  logic            ts_rd_stb,
  output logic [TS_W-1:0] ts_data,
  output logic            ts_valid,
  output logic            ts_empty,
  output logic            empty,
  output logic            full,
  output logic [LW-1:0]   level,
  output logic            overflow,
  output logic            underflow
);
  logic [W-1:0]    cur, prev;
  logic [1:0]      prime;
  logic [TS_W-1:0] tick;
  logic [W-1:0]    mem [DEPTH];
  logic [TS_W-1:0] tmem [DEPTH];
  logic [AW-1:0]   wp, rp, twp, trp;
  logic [LW-1:0]   tlevel, free;
  logic            evt, room, evt_ok, pop, tpop, wide;

  assign wide   = &rd_be;
  assign evt    = (prime == 2'd2) && |((cur ^ prev) & ch_en);
  assign free   = LW'(DEPTH) - level;
  assign room   = soe_mode ? (free >= LW'(2)) : (free >= LW'(1));
  assign evt_ok = evt && room && (tlevel != LW'(DEPTH));
  assign pop    = rd_stb && wide && !empty;
  assign tpop   = ts_rd_stb && !ts_empty;
  assign empty  = (level == '0);
  assign full   = (level == LW'(DEPTH));
  assign ts_empty = (tlevel == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0; prev <= '0; prime <= '0; tick <= '0;
    end else begin
      cur  <= din;
      prev <= cur;
      tick <= tick + 1'b1;
      if (prime != 2'd2) prime <= prime + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (evt_ok) begin
      if (soe_mode) begin
        mem[wp]        <= prev;
        mem[wp + 1'b1] <= cur;
      end else begin
        mem[wp] <= cur;
      end
      tmem[twp] <= tick;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
      twp <= '0; trp <= '0; tlevel <= '0;
      rd_data <= '0; rd_valid <= 1'b0;
      ts_data <= '0; ts_valid <= 1'b0;
      overflow <= 1'b0; underflow <= 1'b0;
    end else begin
      if (evt_ok) begin
        wp  <= wp + (soe_mode ? AW'(2) : AW'(1));
        twp <= twp + 1'b1;
      end
      if (evt && !evt_ok) overflow <= 1'b1;
      level  <= level + (evt_ok ? (soe_mode ? LW'(2) : LW'(1)) : LW'(0)) - LW'(pop);
      tlevel <= tlevel + LW'(evt_ok) - LW'(tpop);

      rd_valid <= rd_stb && wide;
      if (rd_stb && wide) begin
        if (empty) begin
          rd_data   <= '0;
          underflow <= 1'b1;
        end else begin
          rd_data <= mem[rp];
          rp      <= rp + 1'b1;
        end
      end

      ts_valid <= ts_rd_stb;
      if (ts_rd_stb) begin
        if (ts_empty) ts_data <= '0;
        else begin
          ts_data <= tmem[trp];
          trp     <= trp + 1'b1;
        end
      end
    end
  end
endmodule

module cos_event_fifo_chk #(
  parameter int W     = 32,
  parameter int DEPTH = 512,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_stb,
  input logic [3:0]    rd_be,
  input logic [W-1:0]  rd_data,
  input logic          rd_valid,
  input logic          empty,
  input logic [LW-1:0] level,
  input logic          soe_mode,
  input logic          overflow,
  input logic          underflow,
  input logic          evt,
  input logic          evt_ok,
  input logic          pop
);
  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  // R6
  narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !(&rd_be) && !evt_ok) |=> ($stable(level) && !rd_valid));
  // R5
  rd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_stb && (&rd_be)));
  // R8
  underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && (&rd_be) && empty) |=> (underflow && rd_valid && rd_data == '0));
  // R2
  soe_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ok && soe_mode && !pop) |=> (level == LW'($past(level) + LW'(2))));
  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R7
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !evt_ok) |=> overflow);
endmodule

bind cos_event_fifo cos_event_fifo_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_be(rd_be), .rd_data(rd_data),
  .rd_valid(rd_valid), .empty(empty), .level(level), .soe_mode(soe_mode),
  .overflow(overflow), .underflow(underflow), .evt(evt), .evt_ok(evt_ok), .pop(pop)
);

// File: tb/cos_event_fifo_tb.sv
`timescale 1ns/1ps
module cos_event_fifo_tb;
  localparam int W = 32, D = 16, TW = 16, LW = $clog2(D + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, soe_mode = 1'b0, rd_stb = 1'b0, ts_rd_stb = 1'b0;
  logic [W-1:0] din = '0, ch_en = '1;
  logic [3:0] rd_be = 4'hF;
  logic [W-1:0] rd_data;
  logic [TW-1:0] ts_data;
  logic rd_valid, ts_valid, ts_empty, empty, full, overflow, underflow;
  logic [LW-1:0] level;
  int total = 0, failed = 0;

  cos_event_fifo #(.W(W), .DEPTH(D), .TS_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .ch_en(ch_en), .soe_mode(soe_mode),
    .rd_stb(rd_stb), .rd_be(rd_be), .rd_data(rd_data), .rd_valid(rd_valid),
    .ts_rd_stb(ts_rd_stb), .ts_data(ts_data), .ts_valid(ts_valid), .ts_empty(ts_empty),
    .empty(empty), .full(full), .level(level), .overflow(overflow), .underflow(underflow));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rd_stb = 0; ts_rd_stb = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_din(input logic [W-1:0] v);
    din = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic pop(input logic [3:0] be, output logic [W-1:0] d, output logic v);
    rd_be = be; rd_stb = 1;
    @(negedge clk);
    rd_stb = 0; rd_be = 4'hF;
    d = rd_data; v = rd_valid;
  endtask

  task automatic pop_ts(output logic [TW-1:0] t, output logic v);
    ts_rd_stb = 1;
    @(negedge clk);
    ts_rd_stb = 0;
    t = ts_data; v = ts_valid;
  endtask

  task automatic t_reset();
    din = 32'hA5A5_0F0F;
    do_reset();
    chk(empty && ts_empty && level == 0 && !full, "R10 empty after reset", 32'(level), 0);
    chk(!overflow && !underflow, "R10 flags clear", {30'd0, overflow, underflow}, 0);
  endtask

  task automatic t_cos();
    logic [W-1:0] d; logic v;
    do_reset(); soe_mode = 0; ch_en = '1;
    set_din(32'h1234_5678);
    set_din(32'h8000_0001);
    chk(level == 2 && !empty, "R9 level after two events", 32'(level), 2);
    pop(4'hF, d, v);
    chk(v && d == 32'h1234_5678, "R1 first word", d, 32'h1234_5678);
    pop(4'hF, d, v);
    chk(v && d == 32'h8000_0001, "R5 second word in order", d, 32'h8000_0001);
    chk(empty, "R9 empty after drain", 32'(level), 0);
  endtask

  task automatic t_enable();
    logic [W-1:0] d; logic v;
    do_reset(); soe_mode = 0; ch_en = 32'hFFFF_0000;
    set_din(din ^ 32'h0000_0001);
    chk(level == 0, "R4 masked toggle ignored", 32'(level), 0);
    set_din(din ^ 32'h0001_0000);
    chk(level == 1, "R4 enabled toggle stored", 32'(level), 1);
    pop(4'hF, d, v);
    chk(v && d == din, "R1 word includes masked channels", d, din);
    ch_en = '1;
  endtask

  task automatic t_soe();
    logic [W-1:0] d; logic v; logic [TW-1:0] t;
    din = 32'h0000_00C3;
    do_reset(); soe_mode = 1;
    set_din(32'h0000_FF00);
    chk(level == 2, "R2 two words per event", 32'(level), 2);
    pop(4'hF, d, v);
    chk(v && d == 32'h0000_00C3, "R2 before value first", d, 32'h0000_00C3);
    pop(4'hF, d, v);
    chk(v && d == 32'h0000_FF00, "R2 after value second", d, 32'h0000_FF00);
    pop_ts(t, v);
    chk(v && ts_empty, "R3 one stamp per two-word event", {31'd0, ts_empty}, 1);
    soe_mode = 0;
  endtask

  task automatic t_stamp();
    logic [TW-1:0] t1, t2; logic v;
    do_reset(); soe_mode = 0;
    din = 32'h1;
    repeat (7) @(negedge clk);
    din = 32'h2;
    repeat (3) @(negedge clk);
    pop_ts(t1, v);
    pop_ts(t2, v);
    chk(TW'(t2 - t1) == 7, "R3 stamp spacing", 32'(TW'(t2 - t1)), 7);
    chk(ts_empty, "R3 one stamp per event", {31'd0, ts_empty}, 1);
  endtask

  task automatic t_narrow();
    logic [W-1:0] d; logic v;
    do_reset(); soe_mode = 0;
    set_din(32'hDEAD_BEEF);
    pop(4'h7, d, v);
    chk(!v && level == 1, "R6 narrow read ignored", {v, 26'd0, level}, 1);
    pop(4'hF, d, v);
    chk(v && d == 32'hDEAD_BEEF, "R6 word survives narrow read", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_overflow();
    logic [W-1:0] d; logic v;
    din = '0;
    do_reset(); soe_mode = 0;
    for (int i = 1; i <= D; i++) set_din(32'(i) << 4);
    chk(full && level == D, "R9 full at depth", 32'(level), D);
    chk(!overflow, "R7 no overflow when exactly full", {31'd0, overflow}, 0);
    set_din(32'hFFFF_FFFF);
    chk(overflow && level == D, "R7 event dropped when full", {overflow, 26'd0, level}, {1'b1, 26'd0, 5'(D)});
    pop(4'hF, d, v);
    chk(d == 32'h10, "R7 oldest word intact", d, 32'h10);
    chk(overflow, "R7 overflow sticky", {31'd0, overflow}, 1);
  endtask

  task automatic t_soe_room();
    din = '0;
    do_reset(); soe_mode = 0;
    for (int i = 1; i < D; i++) set_din(32'(i));
    chk(level == D - 1, "R7 one slot left", 32'(level), D - 1);
    soe_mode = 1;
    set_din(32'h0F0F_0000);
    chk(level == D - 1 && overflow, "R7 paired write dropped with one slot", {overflow, 26'd0, level}, {1'b1, 26'd0, 5'(D - 1)});
    soe_mode = 0;
    set_din(32'h0000_5555);
    chk(level == D && full, "R7 single write fits last slot", 32'(level), D);
  endtask

  task automatic t_underflow();
    logic [W-1:0] d; logic v;
    do_reset();
    pop(4'hF, d, v);
    chk(v && d == 0, "R8 empty read returns zero", d, 0);
    chk(underflow && level == 0, "R8 underflow flag", {31'd0, underflow}, 1);
    repeat (2) @(negedge clk);
    chk(underflow, "R8 underflow sticky", {31'd0, underflow}, 1);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_cos();
    t_enable();
    t_soe();
    t_stamp();
    t_narrow();
    t_overflow();
    t_soe_room();
    t_underflow();
    finish_run();
  end
endmodule